// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of a read or write burst on a synchronous DRAM. A controller loads a starting column, a three-bit length code and an ordering bit with a start strobe. The block then walks the burst one beat per cycle in which the advance enable is high. While the burst is open it presents the current column, a valid flag, and a flag that marks the final beat.

Two orderings are supported. Sequential order counts upward inside an aligned window of the burst length and wraps inside that window. Interleaved order XORs the beat number into the low bits of the start column. A page-length burst, allowed only with sequential order, runs through the whole 8-bit column space. It wraps indefinitely until it is stopped. The controller can close a burst at any cycle with a stop input. It can also replace the burst on any cycle by issuing a new start, including back-to-back starts on consecutive clocks.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, beat_vld_o, last_o and cfg_err_o are 0.
- R2: Length codes on len_code_i map as 000 to 1 beat, 001 to 2, 010 to 4 and 011 to 8. last_o is 1 exactly on the final beat. An advance on the final beat closes the burst, so beat_vld_o is 0 in the next cycle.
- R3: With order_i = 0 and a length L of 1 to 8, beat k shows the start column with its low log2(L) bits replaced by (start + k) mod L. The upper bits are unchanged.
- R4: With order_i = 1 and a length L of 1 to 8, beat k shows the start column with its low log2(L) bits XORed with k.
- R5: Code 111 with order_i = 0 is a page burst. Beat k shows (start + k) mod 256, last_o never rises, and the burst continues past 256 beats until it is stopped or restarted.
- R6: Codes 100, 101 and 110 with either order, and code 111 with order_i = 1, are reserved. They give a one-beat burst, and cfg_err_o is 1 from the cycle after that start until the next start.
- R7: stop_i without start_i closes an open burst, so beat_vld_o is 0 in the next cycle. While closed, advance_i has no effect.
- R8: start_i opens a new burst in the next cycle whether or not one is open. It overrides stop_i and advance_i in the same cycle, including on the final beat.
- R9: While a burst is open and advance_i is 0, col_o, last_o and beat_vld_o hold their values.
- R10: In the cycle after a start, col_o equals the start column and beat_vld_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Open a new burst, replacing any burst in progress |
| start_col_i | input | 8 | Starting column, sampled with start_i |
| len_code_i | input | 3 | Burst length code, sampled with start_i |
| order_i | input | 1 | 0 for sequential order, 1 for interleaved order, sampled with start_i |
| advance_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | Close the burst now |
| col_o | output | 8 | Column of the current beat, 0 when idle |
| beat_vld_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | The current beat is the final one |
| cfg_err_o | output | 1 | The latest start carried a reserved length code |

## Verification
The restart path can meet the close paths in the same cycle. A new start can arrive on the final beat together with an advance, or together with a stop in the middle of a burst. The bench drives both combinations. It then judges that the following cycle shows beat 0 of the new burst, with the new column, the new length and the new order, and that the rest of the new burst follows its own pattern. A start that comes right after a reserved code checks that the error flag clears on that restart. A sweep over every length code, both orders and start columns that sit at both ends of an aligned window covers the ordering arithmetic.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    // decoded burst shape: interleave, page burst, reserved code, log2 of length
    typedef struct packed {
        logic       ilv;
        logic       full;
        logic       err;
        logic [1:0] lg;
    } bl_info_t;

    function automatic bl_info_t bl_decode(logic [2:0] code, order_e ord);
        bl_info_t r;
        r.ilv  = (ord == ORD_ILV);
        r.full = 1'b0;
        r.err  = 1'b0;
        r.lg   = 2'd0;
        case (code)
            3'b000: r.lg = 2'd0;
            3'b001: r.lg = 2'd1;
            3'b010: r.lg = 2'd2;
            3'b011: r.lg = 2'd3;
            3'b111: begin
                if (ord == ORD_SEQ) r.full = 1'b1;
                else                r.err  = 1'b1;
            end
            default: r.err = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcs_len_dec.sv
module bcs_len_dec
    import bcs_pkg::*;
(
    input  logic [2:0]  code_i,
    input  logic        order_i,
    output bl_info_t    info_o
);

    always_comb begin
        info_o = bl_decode(code_i, order_e'(order_i));
    end

endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             adv_i,
    input  logic             stop_i,
    input  bl_info_t         info_i,
    output logic             active_o,
    output logic [COL_W-1:0] idx_o,
    output logic             last_o,
    output logic             err_o,
    output logic             full_o,
    output logic             ilv_o,
    output logic [1:0]       lg_o
);

    bl_info_t         info_q;
    logic             active_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] lim;

    always_comb begin
        lim    = COL_W'((32'd1 << info_q.lg) - 32'd1);
        last_o = active_q && !info_q.full && (idx_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            info_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            info_q   <= info_i;
        end else if (stop_i) begin
            active_q <= 1'b0;
        end else if (active_q && adv_i) begin
            if (last_o) active_q <= 1'b0;
            else        idx_q    <= idx_q + 1'b1;
        end
    end

    assign active_o = active_q;
    assign idx_o    = idx_q;
    assign err_o    = info_q.err;
    assign full_o   = info_q.full;
    assign ilv_o    = info_q.ilv;
    assign lg_o     = info_q.lg;

    assert_start_opens_R8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> active_q && (idx_q == '0));

    assert_stop_closes_R7: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> !active_q);

    assert_final_closes_R2: assert property (@(posedge clk) disable iff (rst)
        (last_o && adv_i && !start_i && !stop_i) |=> !active_q);

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (active_q && !adv_i && !start_i && !stop_i) |=> active_q && $stable(idx_q));

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic             full_i,
    input  logic             ilv_i,
    input  logic [1:0]       lg_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (start_i) base_q <= start_col_i;
    end

    assign sum = base_q + idx_i;

    // per bit: inside the burst window take the ordered value, outside keep the base
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign mask[b]  = full_i || (32'(lg_i) > b);
        assign col_o[b] = mask[b] ? (ilv_i ? (base_q[b] ^ idx_i[b]) : sum[b])
                                  : base_q[b];
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    input  logic             advance_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o,
    output logic             cfg_err_o
);

    bl_info_t         dec_info;
    logic             active;
    logic [COL_W-1:0] idx;
    logic             full_q;
    logic             ilv_q;
    logic [1:0]       lg_q;
    logic [COL_W-1:0] col_raw;

    bcs_len_dec u_dec (
        .code_i  (len_code_i),
        .order_i (order_i),
        .info_o  (dec_info)
    );

    bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .adv_i    (advance_i),
        .stop_i   (stop_i),
        .info_i   (dec_info),
        .active_o (active),
        .idx_o    (idx),
        .last_o   (last_o),
        .err_o    (cfg_err_o),
        .full_o   (full_q),
        .ilv_o    (ilv_q),
        .lg_o     (lg_q)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .idx_i       (idx),
        .full_i      (full_q),
        .ilv_i       (ilv_q),
        .lg_i        (lg_q),
        .col_o       (col_raw)
    );

    assign beat_vld_o = active;
    assign col_o      = active ? col_raw : '0;

    assert_first_beat_R10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> beat_vld_o && (col_o == $past(start_col_i)));

    assert_reserved_single_R6: assert property (@(posedge clk) disable iff (rst)
        (start_i && dec_info.err) |=> cfg_err_o && last_o && beat_vld_o);

endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = 8'h00;
    logic [2:0] len_code_i = 3'b000;
    logic       order_i = 1'b0;
    logic       advance_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       last_o;
    logic       cfg_err_o;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    burst_col_seq dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .order_i     (order_i),
        .advance_i   (advance_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .beat_vld_o  (beat_vld_o),
        .last_o      (last_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit s, logic [7:0] c, logic [2:0] code, bit ord, bit adv, bit stp);
        @(negedge clk);
        start_i     = s;
        start_col_i = c;
        len_code_i  = code;
        order_i     = ord;
        advance_i   = adv;
        stop_i      = stp;
        @(posedge clk);
        #1;
    endtask

    function automatic bit is_resv(logic [2:0] code, bit ord);
        return (code >= 3'd4 && code <= 3'd6) || (code == 3'd7 && ord);
    endfunction

    function automatic int blen(logic [2:0] code, bit ord);
        if (is_resv(code, ord)) return 1;
        if (code == 3'd7) return 256;
        return 1 << code;
    endfunction

    function automatic int exp_col(int s, logic [2:0] code, bit ord, int k);
        int len = blen(code, ord);
        if (len == 256) return (s + k) % 256;
        if (ord) return (s / len) * len + ((s % len) ^ k);
        return (s / len) * len + ((s + k) % len);
    endfunction

    task automatic run_burst(int s, logic [2:0] code, bit ord);
        int    len  = blen(code, ord);
        bit    full = (len == 256);
        bit    resv = is_resv(code, ord);
        int    nb   = full ? 300 : len;
        string tag;
        tag = resv ? "R6" : (full ? "R5" : (ord ? "R4" : "R3"));
        step(1'b1, 8'(s), code, ord, 1'b0, 1'b0);
        chk("R10 first beat col", col_o, s);
        for (int k = 0; k < nb; k++) begin
            chk({tag, " beat valid"}, beat_vld_o, 1);
            chk({tag, " col"}, col_o, exp_col(s, code, ord, k));
            chk({"R2 ", tag, " last flag"}, last_o, (!full && k == len - 1) ? 1 : 0);
            chk("R6 error flag", cfg_err_o, resv ? 1 : 0);
            if (k < nb - 1 || !full) step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        end
        if (full) begin
            step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1);
            chk("R5 page burst ends on stop", beat_vld_o, 0);
        end else begin
            chk("R2 closed after final beat", beat_vld_o, 0);
            chk("R2 no last when closed", last_o, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int starts[5] = '{0, 5, 62, 251, 255};
        repeat (3) @(posedge clk);
        #1;
        chk("R1 vld in reset", beat_vld_o, 0);
        chk("R1 last in reset", last_o, 0);
        chk("R1 err in reset", cfg_err_o, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 vld after reset", beat_vld_o, 0);
        chk("R1 last after reset", last_o, 0);
        chk("R1 err after reset", cfg_err_o, 0);

        // sweep all length codes, both orders, edge start columns
        for (int o = 0; o < 2; o++)
            for (int c = 0; c < 8; c++)
                foreach (starts[i])
                    run_burst(starts[i], 3'(c), o[0]);

        // R9: stall holds the beat
        step(1'b1, 8'h12, 3'b011, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R3 second beat", col_o, 8'h13);
        for (int j = 0; j < 3; j++) begin
            step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0);
            chk("R9 stall col", col_o, 8'h13);
            chk("R9 stall vld", beat_vld_o, 1);
            chk("R9 stall last", last_o, 0);
        end
        // R7: stop mid burst, then advance while idle
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
        chk("R7 stop closes", beat_vld_o, 0);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R7 idle advance vld", beat_vld_o, 0);
        chk("R7 idle advance col", col_o, 0);
        chk("R7 idle advance last", last_o, 0);

        // R8: restart together with stop and advance mid burst
        step(1'b1, 8'h20, 3'b011, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R3 third beat", col_o, 8'h22);
        step(1'b1, 8'h41, 3'b001, 1'b1, 1'b1, 1'b1);
        chk("R8 restart over stop vld", beat_vld_o, 1);
        chk("R8 restart over stop col", col_o, 8'h41);
        chk("R8 restart over stop last", last_o, 0);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 new interleave beat", col_o, 8'h40);
        chk("R8 new burst final", last_o, 1);
        // R8: restart on the final beat together with advance
        step(1'b1, 8'h7D, 3'b010, 1'b0, 1'b1, 1'b0);
        chk("R8 restart on final vld", beat_vld_o, 1);
        chk("R8 restart on final col", col_o, 8'h7D);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 follow col 1", col_o, 8'h7E);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 follow col 2", col_o, 8'h7F);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 follow col 3", col_o, 8'h7C);
        chk("R8 follow last", last_o, 1);

        // R6: error flag clears on next valid start
        step(1'b1, 8'h33, 3'b101, 1'b0, 1'b0, 1'b0);
        chk("R6 reserved err", cfg_err_o, 1);
        chk("R6 reserved single beat", last_o, 1);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R6 err held after burst", cfg_err_o, 1);
        step(1'b1, 8'h34, 3'b000, 1'b0, 1'b0, 1'b0);
        chk("R6 err cleared by start", cfg_err_o, 0);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule